// File: doc/BRIEF.md
# Dual-Section Decade Counter with Nine Preset

The block is a synchronous decade counter split into two sections. One is a single-bit toggle stage that divides by two. The other is a three-bit stage that divides by five. Each section has its own count input, and a count input advances a section on a falling edge. A two-bit mode input sets how the sections are chained. In split mode the two sections run apart. In packed-decimal mode the toggle stage feeds the quinary stage, so the output counts 0 to 9 in 8-4-2-1 code. In biquinary mode the quinary stage feeds the toggle stage, so the toggle bit is a square wave at one tenth of the input rate with a 50% duty cycle.

The count inputs may be asynchronous to the system clock. Each one passes through a synchronizer chain of flip-flops. A falling edge is then detected on the synchronized level, and each edge gives exactly one advance. The block has two gated controls. A pair of zero inputs clears the count, and a pair of nine inputs loads decimal nine for nines-complement work. A control acts only when both of its inputs are high.

Top module: `decade_dual_counter`

## Requirements
- R1: While `rst` is high on a clock edge, `q` becomes 4'b0000. `q[0]` is the toggle bit, and `q[3:1]` is the quinary code with `q[1]` as its least significant bit.
- R2: With `mode` = 0, each falling edge of `tick_b` steps `q[3:1]` through 000, 001, 010, 011, 100 and back to 000. The codes 101, 110 and 111 never appear on `q[3:1]`.
- R3: With `mode` = 0 or `mode` = 3, each falling edge of `tick_a` inverts `q[0]` and leaves `q[3:1]` unchanged.
- R4: When `zero_a` and `zero_b` are both high on a clock edge, `q` becomes 0000. If only one of them is high, `q` does not change.
- R5: When `nine_a` and `nine_b` are both high on a clock edge, `q` becomes 1001, even if both zero inputs are also high. If only one nine input is high, `q` does not change.
- R6: With `mode` = 1, each falling edge of `tick_a` moves `q` to the next value in the order 0, 1, 2, ..., 9, 0. Edges on `tick_b` are ignored.
- R7: With `mode` = 2, each falling edge of `tick_b` advances `q[3:1]`. `q[0]` inverts only when `q[3:1]` wraps from 100 to 000. Edges on `tick_a` are ignored.
- R8: A rising edge on a count input does not change `q`. One falling edge gives exactly one advance.
- R9: When a count input falls just before clock edge E0, `q` is still unchanged after edge E1. The new value appears after edge E2, with two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_a | input | 1 | Count input of the toggle section, active on falling edges |
| tick_b | input | 1 | Count input of the quinary section, active on falling edges |
| mode | input | 2 | 0 split, 1 packed decimal, 2 biquinary, 3 split |
| zero_a | input | 1 | Clear gate, first input |
| zero_b | input | 1 | Clear gate, second input |
| nine_a | input | 1 | Nine-preset gate, first input |
| nine_b | input | 1 | Nine-preset gate, second input |
| q | output | 4 | Count: q[0] toggle bit, q[3:1] quinary code |

## Verification
The bench builds the block with the default of two synchronizer stages. With that value the three-edge latency of a falling count edge is a fixed number, and the bench checks it directly. Long random runs then mix count pulses on both inputs, mode changes made between counts, single and paired control inputs, and preset combined with clear. This reaches the decimal wrap from 9 to 0, the quinary wrap that toggles the biquinary bit, and every case where one input is ignored.

// File: rtl/decade_pkg.sv
package decade_pkg;

    localparam int QUIN_W    = 3;
    localparam int QUIN_MOD  = 5;
    localparam logic [QUIN_W-1:0] QUIN_LAST = QUIN_W'(QUIN_MOD - 1);

    typedef enum logic [1:0] {
        MODE_SPLIT  = 2'd0,
        MODE_PACKED = 2'd1,
        MODE_BIQ    = 2'd2,
        MODE_SPLIT2 = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        FORCE_NONE = 2'd0,
        FORCE_ZERO = 2'd1,
        FORCE_NINE = 2'd2
    } force_e;

    typedef struct packed {
        logic [QUIN_W-1:0] quin;
        logic              bin;
    } count_s;

    localparam count_s COUNT_ZERO = '{quin: '0, bin: 1'b0};
    localparam count_s COUNT_NINE = '{quin: QUIN_LAST, bin: 1'b1};

    function automatic logic [QUIN_W-1:0] quin_next(input logic [QUIN_W-1:0] cur);
        if (cur >= QUIN_LAST) return '0;
        return cur + 1'b1;
    endfunction

    function automatic force_e force_decode(input logic za, input logic zb,
                                            input logic na, input logic nb);
        if (na && nb) return FORCE_NINE;
        if (za && zb) return FORCE_ZERO;
        return FORCE_NONE;
    endfunction

endpackage

// File: rtl/fall_detect.sv
module fall_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign fall = last_q & ~sync_q[STAGES-1];

    // An edge must give a one-cycle pulse, never a run of pulses
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall) else $error("fall pulse lasted more than one cycle"); // R8

endmodule

// File: rtl/div2_stage.sv
module div2_stage (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic load_val,
    input  logic adv,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= 1'b0;
        else if (load) q <= load_val;
        else if (adv)  q <= ~q;
    end

    AST_BIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(q)) else $error("toggle bit moved without cause"); // R8

endmodule

// File: rtl/div5_stage.sv
module div5_stage
    import decade_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [QUIN_W-1:0] load_val,
    input  logic              adv,
    output logic [QUIN_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= load_val;
        else if (adv)  q <= quin_next(q);
    end

    AST_QUIN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        q <= QUIN_LAST) else $error("quinary code out of range"); // R2

    AST_QUIN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!load && adv && q == QUIN_LAST) |=> q == '0) else $error("quinary wrap missed"); // R2

    AST_QUIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv) |=> $stable(q)) else $error("quinary moved without cause"); // R8

endmodule

// File: rtl/decade_dual_counter.sv
module decade_dual_counter
    import decade_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_a,
    input  logic       tick_b,
    input  logic [1:0] mode,
    input  logic       zero_a,
    input  logic       zero_b,
    input  logic       nine_a,
    input  logic       nine_b,
    output logic [3:0] q
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] tick_in;
    logic [N_IN-1:0] fall;
    count_s          cnt;
    count_s          load_val;
    force_e          force_k;
    mode_e           mode_k;
    logic            adv_bin;
    logic            adv_quin;
    logic            load;

    assign tick_in = {tick_b, tick_a};

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_in
            fall_detect #(.STAGES(SYNC_STAGES)) u_fd (
                .clk  (clk),
                .rst  (rst),
                .din  (tick_in[i]),
                .fall (fall[i])
            );
        end
    endgenerate

    assign mode_k  = mode_e'(mode);
    assign force_k = force_decode(zero_a, zero_b, nine_a, nine_b);
    assign load    = (force_k != FORCE_NONE);

    always_comb begin
        load_val = (force_k == FORCE_NINE) ? COUNT_NINE : COUNT_ZERO;
        unique case (mode_k)
            MODE_PACKED: begin
                adv_bin  = fall[0];
                adv_quin = fall[0] & cnt.bin;
            end
            MODE_BIQ: begin
                adv_quin = fall[1];
                adv_bin  = fall[1] & (cnt.quin == QUIN_LAST);
            end
            default: begin
                adv_bin  = fall[0];
                adv_quin = fall[1];
            end
        endcase
    end

    div2_stage u_bin (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val.bin),
        .adv      (adv_bin),
        .q        (cnt.bin)
    );

    div5_stage u_quin (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val.quin),
        .adv      (adv_quin),
        .q        (cnt.quin)
    );

    assign q = cnt;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (zero_a && zero_b && !(nine_a && nine_b)) |=> q == 4'b0000) else $error("clear failed"); // R4

    AST_PRESET_NINE: assert property (@(posedge clk) disable iff (rst)
        (nine_a && nine_b) |=> q == 4'b1001) else $error("preset failed"); // R5

    AST_DECADE_RANGE: assert property (@(posedge clk) disable iff (rst)
        q <= 4'd9) else $error("count above nine"); // R6

    AST_PACKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1 && !load && !q[0]) |=> $stable(q[3:1])) else $error("decimal carry without toggle fall"); // R6

    AST_BIQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && !load && q[3:1] != QUIN_LAST) |=> $stable(q[0])) else $error("biquinary bit moved early"); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fall == '0 && !load) |=> $stable(q)) else $error("count moved with no edge"); // R8

endmodule

// File: tb/tb_decade_dual_counter.sv
module tb_decade_dual_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_a = 1'b1;
    logic       tick_b = 1'b1;
    logic [1:0] mode = 2'd0;
    logic       zero_a = 1'b0;
    logic       zero_b = 1'b0;
    logic       nine_a = 1'b0;
    logic       nine_b = 1'b0;
    logic [3:0] q;

    int n_chk  = 0;
    int n_fail = 0;

    logic       m_bin  = 1'b0;
    logic [2:0] m_quin = 3'd0;

    always #2 clk = ~clk;

    decade_dual_counter dut (
        .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b), .mode(mode),
        .zero_a(zero_a), .zero_b(zero_b), .nine_a(nine_a), .nine_b(nine_b), .q(q)
    );

    function automatic logic [2:0] qn(input logic [2:0] v);
        return (v == 3'd4) ? 3'd0 : v + 3'd1;
    endfunction

    function automatic logic [3:0] expv();
        return {m_quin, m_bin};
    endfunction

    task automatic model_fall(input int ch);
        case (mode)
            2'd1: if (ch == 0) begin
                if (m_bin) m_quin = qn(m_quin);
                m_bin = ~m_bin;
            end
            2'd2: if (ch == 1) begin
                if (m_quin == 3'd4) m_bin = ~m_bin;
                m_quin = qn(m_quin);
            end
            default: begin
                if (ch == 0) m_bin = ~m_bin;
                else         m_quin = qn(m_quin);
            end
        endcase
    endtask

    task automatic check(input string tag, input logic [3:0] exp);
        n_chk++;
        if (q !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, q, exp);
        end
    endtask

    task automatic set_tick(input int ch, input logic v);
        if (ch == 0) tick_a = v;
        else         tick_b = v;
    endtask

    task automatic pulse(input int ch, input string tag);
        @(negedge clk);
        set_tick(ch, 1'b0);
        repeat (4) @(negedge clk);
        model_fall(ch);
        check(tag, expv());
        set_tick(ch, 1'b1);
        repeat (4) @(negedge clk);
        check("R8 rising edge", expv());
    endtask

    task automatic control(input logic za, input logic zb, input logic na, input logic nb,
                           input string tag);
        @(negedge clk);
        zero_a = za; zero_b = zb; nine_a = na; nine_b = nb;
        @(negedge clk);
        zero_a = 1'b0; zero_b = 1'b0; nine_a = 1'b0; nine_b = 1'b0;
        if (na && nb) begin m_bin = 1'b1; m_quin = 3'd4; end
        else if (za && zb) begin m_bin = 1'b0; m_quin = 3'd0; end
        check(tag, expv());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0a17));
        repeat (3) @(negedge clk);
        check("R1 reset", 4'b0000);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 after reset", 4'b0000);

        // R2 quinary sequence in split mode
        for (int i = 0; i < 6; i++) pulse(1, "R2 quinary step");
        // R3 toggle bit alone
        pulse(0, "R3 toggle split");
        mode = 2'd3;
        pulse(0, "R3 toggle mode3");

        // R9 latency: fall presented before edge E0
        @(negedge clk);
        tick_a = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check("R9 unchanged after E1", expv());
        model_fall(0);
        @(posedge clk); #1;
        check("R9 updated after E2", expv());
        @(negedge clk); repeat (3) @(negedge clk);
        tick_a = 1'b1;
        repeat (4) @(negedge clk);

        // R4 and R5 gating
        mode = 2'd0;
        pulse(1, "R2 step");
        control(1'b1, 1'b0, 1'b0, 1'b0, "R4 single zero ignored");
        control(1'b0, 1'b1, 1'b0, 1'b0, "R4 single zero ignored");
        control(1'b1, 1'b1, 1'b0, 1'b0, "R4 clear");
        control(1'b0, 1'b0, 1'b1, 1'b0, "R5 single nine ignored");
        control(1'b0, 1'b0, 1'b0, 1'b1, "R5 single nine ignored");
        control(1'b1, 1'b1, 1'b1, 1'b1, "R5 preset beats clear");

        // R6 packed decimal
        mode = 2'd1;
        control(1'b1, 1'b1, 1'b0, 1'b0, "R4 clear");
        for (int i = 0; i < 12; i++) pulse(0, "R6 decimal step");
        pulse(1, "R6 tick_b ignored");

        // R7 biquinary
        mode = 2'd2;
        control(1'b1, 1'b1, 1'b0, 1'b0, "R4 clear");
        for (int i = 0; i < 11; i++) pulse(1, "R7 biquinary step");
        pulse(0, "R7 tick_a ignored");

        // random mix
        for (int i = 0; i < 300; i++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 4)       pulse(0, "R3 R6 random tick_a");
            else if (op < 8)  pulse(1, "R2 R7 random tick_b");
            else if (op == 8) begin
                logic [3:0] c;
                c = 4'($urandom);
                control(c[0], c[1], c[2], c[3], "R4 R5 random control");
            end else begin
                @(negedge clk);
                mode = 2'($urandom);
            end
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule